// File: doc/BRIEF.md
# Paging Address Translator with Table Walker

This block turns a 32-bit linear address into a physical address using 4 KiB pages. A small fully associative cache holds recent page translations. When an access hits the cache, the upper 20 address bits are replaced by the cached frame number, and the 12-bit page offset passes through unchanged. When an access misses, a hardware walker reads a directory entry and then a page-table entry through a memory port that allows one outstanding request. It installs the result in the cache and then completes the stalled access.

Accessed and dirty flags in memory are never left stale. When a flag must be set, the walker re-reads the entry with the bus locked, ORs in only the missing flag, and writes the word back while the lock is still held. The cache therefore never holds modified state, and evicting an entry needs no write-back. A write that hits a cached entry whose dirty flag is clear re-walks the tables, so that the memory copy gets its dirty flag first.

A requester presents one address at a time with a read/write flag. A response arrives as a one-cycle pulse carrying the physical address, or a fault with a cause code. Software-owned inputs give the directory base frame, a paging enable and a flush strobe.

Top module: `pg_xlate`

## Requirements
- R1: With `pg_en` low, an accepted request responds one cycle later with `rsp_phys` equal to the linear address, no fault, and no memory access.
- R2: A read that hits the cache responds one cycle after acceptance with no memory access. The response is `{frame, lin[11:0]}`, where `frame` is bits 31:12 of the installed table entry.
- R3: On a miss, the walker reads the directory word at `{dir_base,12'h000} + lin[31:22]*4` and then the table word at `{dir_word[31:12],12'h000} + lin[21:12]*4`. The translated address uses `table_word[31:12]` as the frame.
- R4: A successful walk installs its translation, so a later read of the same page hits with no memory traffic.
- R5: An entry with bit 0 (present) clear faults and is not cached. A clear bit at the directory level gives `rsp_cause`=1, and a clear bit at the table level gives `rsp_cause`=2. The fault response carries the linear address in `rsp_phys`, and `rsp_cause` is 0 on every non-fault response.
- R6: When bit 5 (accessed) of a directory or table entry is clear, the walker performs a locked read and then a locked write of the same word. The write sets only that bit, `mem_lock` stays high across both transfers, and no write is ever issued without the lock.
- R7: A read leaves bit 6 (dirty) unchanged. A write to a page whose dirty bit is clear, whether it hits or misses, sets bit 6 in memory through a locked update. After that, writes to the page hit with no memory traffic.
- R8: A one-cycle `flush` pulse invalidates every cached translation.
- R9: Misses fill the lowest-numbered free slot. Once all slots are full, victims are chosen round-robin starting at slot 0.
- R10: `req_ready` is low from acceptance of a miss until its response, so only one access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| dir_base | input | 20 | Frame number of the page directory |
| pg_en | input | 1 | Paging enable |
| flush | input | 1 | Invalidate all cached translations |
| rsp_valid | output | 1 | Response pulse |
| rsp_phys | output | 32 | Physical address, or the linear address on a fault |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 2 | 1 directory not present, 2 table entry not present, 0 otherwise |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_lock | output | 1 | Bus lock for read-modify-write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Transfer completes in a cycle where `mem_req` and `mem_ack` are both high |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest situations to reach from the ports are eviction under a full cache and the re-walk triggered by a write hit on a clean entry. For eviction, the bench flushes the cache and then walks 32 distinct pages, so that it knows exactly which slot each page occupies. It then adds further pages and probes neighbouring pages for hit or miss, observing this through the number of memory reads. For the clean-write case, the bench first caches a page through a read. It then writes the page and counts one locked write, and checks that the table word in the memory model gained exactly the dirty bit.

// File: rtl/pg_xlate.sv
`timescale 1ns/1ps
module pg_xlate #(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic [19:0] dir_base,
  input  logic        pg_en,
  input  logic        flush,
  output logic        rsp_valid,
  output logic [31:0] rsp_phys,
  output logic        rsp_fault,
  output logic [1:0]  rsp_cause,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_lock,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int P_BIT = 0;
  localparam int A_BIT = 5;
  localparam int D_BIT = 6;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_TBL, S_LKR, S_LKW} st_t;

  st_t st;
  logic [19:0] tag [ENTRIES];
  logic [19:0] frm [ENTRIES];
  logic [ENTRIES-1:0] vld, dty, hit_v;
  logic [IW-1:0] hidx, vic, rr, tgt;
  logic hit, full;
  logic [31:0] lin_q, lk_addr, lk_data, lk_mask, upd_mask, dir_addr, tbl_addr, inst_word;
  logic [19:0] dir_q, ptb;
  logic wr_q, lk_lvl, inst;
  logic done;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_v[g] = vld[g] && (tag[g] == req_lin[31:12]);
  end

  assign hit  = |hit_v;
  assign full = &vld;

  always_comb begin
    hidx = '0;
    for (int i = 0; i < ENTRIES; i++) if (hit_v[i]) hidx = IW'(i);
  end

  always_comb begin
    vic = rr;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!vld[i]) vic = IW'(i);
  end

  assign dir_addr = {dir_q, 12'h000} | {20'h0, lin_q[31:22], 2'b00};
  assign tbl_addr = {ptb, 12'h000} | {20'h0, lin_q[21:12], 2'b00};
  assign upd_mask = (mem_rdata[A_BIT] ? 32'd0 : (32'd1 << A_BIT))
                  | ((wr_q && !mem_rdata[D_BIT]) ? (32'd1 << D_BIT) : 32'd0);

  assign req_ready = (st == S_IDLE) && !flush;
  assign mem_req   = (st != S_IDLE);
  assign mem_lock  = (st == S_LKR) || (st == S_LKW);
  assign mem_we    = (st == S_LKW);
  assign mem_wdata = lk_data | lk_mask;
  assign mem_addr  = (st == S_DIR) ? dir_addr : (st == S_TBL) ? tbl_addr : lk_addr;

  assign done = mem_req && mem_ack;
  assign inst = done && (((st == S_TBL) && mem_rdata[P_BIT] && (upd_mask == 32'd0))
                       || ((st == S_LKW) && lk_lvl));
  assign inst_word = (st == S_TBL) ? mem_rdata : (lk_data | lk_mask);

  always_ff @(posedge clk) begin
    if (inst) begin
      tag[tgt] <= lin_q[31:12];
      frm[tgt] <= inst_word[31:12];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      vld <= '0;
      dty <= '0;
      rr <= '0;
      tgt <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_phys <= '0;
      lin_q <= '0;
      dir_q <= '0;
      wr_q <= 1'b0;
      ptb <= '0;
      lk_lvl <= 1'b0;
      lk_addr <= '0;
      lk_data <= '0;
      lk_mask <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
      if (inst) begin
        vld[tgt] <= 1'b1;
        dty[tgt] <= inst_word[D_BIT];
      end
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          lin_q <= req_lin;
          wr_q  <= req_write;
          dir_q <= dir_base;
          if (!pg_en) begin
            rsp_valid <= 1'b1;
            rsp_phys  <= req_lin;
          end else if (hit && (!req_write || dty[hidx])) begin
            rsp_valid <= 1'b1;
            rsp_phys  <= {frm[hidx], req_lin[11:0]};
          end else begin
            st <= S_DIR;
            if (hit) begin
              tgt <= hidx;
              vld[hidx] <= 1'b0;
            end else begin
              tgt <= vic;
              if (full) rr <= (rr == IW'(ENTRIES - 1)) ? '0 : rr + 1'b1;
            end
          end
        end
        S_DIR: if (done) begin
          if (!mem_rdata[P_BIT]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_cause <= 2'd1;
            rsp_phys  <= lin_q;
            st <= S_IDLE;
          end else begin
            ptb <= mem_rdata[31:12];
            if (!mem_rdata[A_BIT]) begin
              lk_lvl  <= 1'b0;
              lk_addr <= dir_addr;
              lk_mask <= 32'd1 << A_BIT;
              st <= S_LKR;
            end else begin
              st <= S_TBL;
            end
          end
        end
        S_TBL: if (done) begin
          if (!mem_rdata[P_BIT]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_cause <= 2'd2;
            rsp_phys  <= lin_q;
            st <= S_IDLE;
          end else if (upd_mask != 32'd0) begin
            lk_lvl  <= 1'b1;
            lk_addr <= tbl_addr;
            lk_mask <= upd_mask;
            st <= S_LKR;
          end else begin
            rsp_valid <= 1'b1;
            rsp_phys  <= {mem_rdata[31:12], lin_q[11:0]};
            st <= S_IDLE;
          end
        end
        S_LKR: if (done) begin
          lk_data <= mem_rdata;
          st <= S_LKW;
        end
        S_LKW: if (done) begin
          if (!lk_lvl) begin
            ptb <= lk_data[31:12];
            st <= S_TBL;
          end else begin
            rsp_valid <= 1'b1;
            rsp_phys  <= {lk_data[31:12], lin_q[11:0]};
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (flush) vld <= '0;
    end
  end
endmodule

// File: rtl/pg_xlate_chk.sv
`timescale 1ns/1ps
module pg_xlate_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [31:0]        req_lin,
  input logic               pg_en,
  input logic               flush,
  input logic               rsp_valid,
  input logic [31:0]        rsp_phys,
  input logic               rsp_fault,
  input logic [1:0]         rsp_cause,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_lock,
  input logic               mem_ack,
  input logic [31:0]        lin_q,
  input logic [ENTRIES-1:0] vld
);
  AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pg_en) |=> (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin))); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_phys[11:0] == lin_q[11:0])); // R2
  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_cause == 2'd1 || rsp_cause == 2'd2)); // R5
  AST_NO_STRAY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0)); // R5
  AST_LOCKED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_lock && !mem_we) |=> (mem_req && mem_we && mem_lock)); // R6
  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_lock); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0)); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10
endmodule

bind pg_xlate pg_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/test_pg_xlate.sv
`timescale 1ns/1ps
module test_pg_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pg_en = 1'b1, flush = 1'b0;
  logic [31:0] req_lin = '0;
  logic [19:0] dir_base = 20'h00010;
  logic req_ready, rsp_valid, rsp_fault, mem_req, mem_we, mem_lock;
  logic [1:0] rsp_cause;
  logic [31:0] rsp_phys, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic poke_en = 1'b0;
  logic [31:0] poke_addr = '0, poke_data = '0;
  logic [31:0] mem [logic [31:0]];
  int n_rd = 0, n_lw = 0, n_chk = 0, n_err = 0, cyc = 0;

  always #5 clk = ~clk;

  pg_xlate i_pg_xlate (.*);

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (poke_en) mem[poke_addr] = poke_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (mem_lock) n_lw++;
      end else begin
        n_rd++;
      end
    end
  end

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic xl(input logic [31:0] lin, input logic wr,
                    output logic [31:0] phys, output logic flt, output logic [1:0] cause,
                    output int lat, output int nr, output int nl, output logic busy);
    int r0, l0;
    @(negedge clk);
    r0 = n_rd; l0 = n_lw;
    req_valid = 1'b1; req_lin = lin; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    lat = 1;
    busy = !req_ready;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    phys = rsp_phys; flt = rsp_fault; cause = rsp_cause;
    nr = n_rd - r0; nl = n_lw - l0;
  endtask

  logic [31:0] ph; logic fl; logic [1:0] ca; int lat, nr, nl; logic bz;

  task automatic t_reset();
    chk("R10 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 no response at reset", {31'b0, rsp_valid}, 32'd0);
    chk("R3 no memory request at reset", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_bypass();
    pg_en = 1'b0;
    xl(32'hDEADBEEF, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R1 bypass address", ph, 32'hDEADBEEF);
    chk("R1 bypass latency", lat, 1);
    chk("R1 bypass no reads", nr, 0);
    pg_en = 1'b1;
  endtask

  task automatic t_miss_hit();
    xl(32'h00005ABC, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R3 walk result", ph, 32'h12345ABC);
    chk("R3 walk reads", nr, 2);
    chk("R3 walk no update", nl, 0);
    chk("R10 busy during walk", {31'b0, bz}, 32'd1);
    xl(32'h00005010, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R2 hit result", ph, 32'h12345010);
    chk("R2 hit latency", lat, 1);
    chk("R4 hit no reads", nr, 0);
  endtask

  task automatic t_write_hit_clean();
    xl(32'h00005020, 1'b1, ph, fl, ca, lat, nr, nl, bz);
    chk("R7 write hit clean result", ph, 32'h12345020);
    chk("R7 write hit clean locked writes", nl, 1);
    chk("R7 dirty set in memory", peek(32'h00020014), 32'h12345061);
    xl(32'h00005030, 1'b1, ph, fl, ca, lat, nr, nl, bz);
    chk("R7 later write hits", nr, 0);
    chk("R7 later write latency", lat, 1);
  endtask

  task automatic t_accessed_tbl();
    xl(32'h00006100, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R6 result after update", ph, 32'h0ABCD100);
    chk("R6 one locked write", nl, 1);
    chk("R6 only accessed set", peek(32'h00020018), 32'h0ABCD021);
    xl(32'h00006104, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R4 installed after update", nr, 0);
  endtask

  task automatic t_faults();
    xl(32'h00007004, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R5 table fault flag", {31'b0, fl}, 32'd1);
    chk("R5 table fault cause", {30'b0, ca}, 32'd2);
    chk("R5 fault address", ph, 32'h00007004);
    xl(32'h00007008, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R5 fault not cached", nr, 2);
    xl(32'h00400000, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R5 directory fault cause", {30'b0, ca}, 32'd1);
    chk("R5 directory fault reads", nr, 1);
  endtask

  task automatic t_accessed_dir();
    xl(32'h00800FFF, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R6 directory update result", ph, 32'h33333FFF);
    chk("R6 directory locked write", nl, 1);
    chk("R6 directory accessed set", peek(32'h00010008), 32'h00022021);
  endtask

  task automatic t_write_miss();
    xl(32'h00008008, 1'b1, ph, fl, ca, lat, nr, nl, bz);
    chk("R7 write miss result", ph, 32'h44444008);
    chk("R7 write miss dirty set", peek(32'h00020020), 32'h44444061);
    xl(32'h0000900C, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R7 read leaves dirty clear", peek(32'h00020024), 32'h55555021);
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xl(32'h00005040, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R8 miss after flush", nr, 2);
    chk("R8 result after flush", ph, 32'h12345040);
  endtask

  task automatic t_replace();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 34; i++) poke(32'h00021000 + 32'(i) * 4, ((32'h80000 + 32'(i)) << 12) | 32'h061);
    for (int i = 0; i < 33; i++) xl(32'h40000000 + (32'(i) << 12), 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R9 last fill result", ph, 32'h80020000);
    xl(32'h40001000, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R9 page in slot 1 kept", nr, 0);
    xl(32'h40000000, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R9 slot 0 evicted first", nr, 2);
    xl(32'h40001000, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R9 slot 1 evicted next", nr, 2);
    xl(32'h40003000, 1'b0, ph, fl, ca, lat, nr, nl, bz);
    chk("R9 slot 3 kept", nr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    poke(32'h00010000, 32'h00020021);
    poke(32'h00010004, 32'h00000000);
    poke(32'h00010008, 32'h00022001);
    poke(32'h00010400, 32'h00021021);
    poke(32'h00020014, 32'h12345021);
    poke(32'h00020018, 32'h0ABCD001);
    poke(32'h0002001C, 32'h77777000);
    poke(32'h00020020, 32'h44444021);
    poke(32'h00020024, 32'h55555021);
    poke(32'h00022000, 32'h33333021);
    t_reset();
    t_bypass();
    t_miss_hit();
    t_write_hit_clean();
    t_accessed_tbl();
    t_faults();
    t_accessed_dir();
    t_write_miss();
    t_flush();
    t_replace();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule